// File: doc/BRIEF.md
# Twelve-Pin GPIO Controller with LED and Timestamp Alternates

This block controls twelve general-purpose pins from a small synchronous register port. Each pin can be an input, a push-pull output or an open-drain output. Each pin can also raise a level-sensitive interrupt whose active level is chosen per pin. The pin side has three signals per pin: an output value, an output enable and a raw input level. The raw input passes through a two-flop synchronizer before it is used for readback or for interrupt detection.

Pins 7:0 can be handed over to LED status signals. Whether each of these pins starts in LED mode depends on a strap input that is captured during reset. Software can change the choice later. Pins 9:8 can be driven by an external timestamp-compare unit. On these two pins the effective output enable is the OR of the register direction bit and the enable from that unit.

All pad outputs, the interrupt line and the read data are registered.

Top module: `gpx_pin_ctrl`

## Requirements
- R1: While `rst` is high, the direction, buffer-type, data, interrupt-enable, polarity and status bits all clear, and `pad_oe` and `irq` are 0. The LED-mode register loads `strap_led`.
- R2: Register map, by word address:
  - 0 holds direction in bits 11:0 (1 = output) and buffer type in bits 27:16.
  - 2 holds interrupt enable in bits 11:0 and polarity in bits 27:16.
  - 4 holds the LED-mode bits in 7:0.
  - Written fields read back unchanged. Unused bits and addresses 5 to 7 read as 0.
- R3: An output pin with buffer type 1 (open-drain) gives `pad_oe`=1 and `pad_out`=0 when its data bit is 0. It gives `pad_oe`=0 when its data bit is 1.
- R4: An output pin with buffer type 0 (push-pull) gives `pad_oe`=1 and `pad_out` equal to its data bit.
- R5: An input pin is not driven. A read of address 1 returns the synchronized pin level for input pins and the stored data bit for output pins.
- R6: A change on `pad_in` first shows in the read data of address 1 three clock edges after it is applied. These are the two synchronizer stages plus the read register.
- R7: Status bit i (address 3) becomes 1 when enable i is set and the synchronized level equals polarity i (0 = low, 1 = high). It then holds. Writing 1 to it clears it, except that a still-present condition wins over the clear.
- R8: `irq` is the registered OR over all pins of status AND enable. It follows status by one clock.
- R9: A pin of 7:0 in LED mode ignores its direction and data bits. Its `led_on`=1 gives `pad_oe`=1 and `pad_out`=0, and its `led_on`=0 releases the pin. Its status bit stays 0.
- R10: On pins 9:8, the output enable is the direction bit OR `ts_oe`. While `ts_oe` is high the value comes from `ts_val`, and the pin's buffer type still applies.
- R11: `pad_oe` and `pad_out` change on the clock edge after the one that stores a new register value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_led | input | 8 | LED-mode straps for pins 7:0, captured during reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| led_on | input | 8 | LED status request for pins 7:0 (1 = lit) |
| ts_oe | input | 2 | Timestamp-unit output enable for pins 9:8 |
| ts_val | input | 2 | Timestamp-unit output value for pins 9:8 |
| pad_in | input | 12 | Raw pin levels |
| pad_out | output | 12 | Pin output values |
| pad_oe | output | 12 | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
Each stored configuration bit reaches `pad_oe`/`pad_out` within one clock and reaches `reg_rdata` one clock after it is addressed. A wrong direction, buffer-type or LED-mode bit therefore shows at the ports in the very next cycle. A stuck status bit shows on `irq` one clock later, or in a status read. A wrong synchronizer depth moves the readback edge away from its expected third clock. This is caught because the model is compared against the outputs on every cycle.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int unsigned OFS_DIRBUF = 0;
  localparam int unsigned OFS_DATA   = 1;
  localparam int unsigned OFS_IRQCFG = 2;
  localparam int unsigned OFS_STAT   = 3;
  localparam int unsigned OFS_LED    = 4;

  typedef enum logic {
    BUF_PUSHPULL  = 1'b0,
    BUF_OPENDRAIN = 1'b1
  } gpx_buf_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
#(
  parameter int NPINS  = 12,
  parameter int NLED   = 8,
  parameter int AW     = 3,
  parameter int DW     = 32,
  parameter int HI_OFS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NLED-1:0]  strap,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [NPINS-1:0] sync_in,
  output logic [NPINS-1:0] dir_o,
  output logic [NPINS-1:0] bufod_o,
  output logic [NPINS-1:0] dat_o,
  output logic [NPINS-1:0] ie_o,
  output logic [NPINS-1:0] st_o,
  output logic [NLED-1:0]  led_o,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_o
);
  logic [NPINS-1:0] dir_q, bufod_q, dat_q, ie_q, pol_q, st_q;
  logic [NLED-1:0]  led_q;
  logic [NPINS-1:0] led_pin, outsel, rb, w1c, hit, st_d;
  logic [DW-1:0]    rd_d;
  logic             wr_dirbuf, wr_data, wr_irqcfg, wr_stat, wr_led;

  assign wr_dirbuf = we && (addr == AW'(OFS_DIRBUF));
  assign wr_data   = we && (addr == AW'(OFS_DATA));
  assign wr_irqcfg = we && (addr == AW'(OFS_IRQCFG));
  assign wr_stat   = we && (addr == AW'(OFS_STAT));
  assign wr_led    = we && (addr == AW'(OFS_LED));

  assign led_pin = NPINS'(led_q);
  assign outsel  = dir_q & ~led_pin;
  assign rb      = (outsel & dat_q) | (~outsel & sync_in);
  assign w1c     = wr_stat ? wdata[NPINS-1:0] : '0;
  assign hit     = ie_q & ~led_pin & ~(sync_in ^ pol_q);
  assign st_d    = ((st_q & ~w1c) | hit) & ~led_pin;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      bufod_q <= '0;
      dat_q   <= '0;
      ie_q    <= '0;
      pol_q   <= '0;
      st_q    <= '0;
      led_q   <= strap;
    end else begin
      if (wr_dirbuf) begin
        dir_q   <= wdata[NPINS-1:0];
        bufod_q <= wdata[HI_OFS +: NPINS];
      end
      if (wr_data) dat_q <= wdata[NPINS-1:0];
      if (wr_irqcfg) begin
        ie_q  <= wdata[NPINS-1:0];
        pol_q <= wdata[HI_OFS +: NPINS];
      end
      if (wr_led) led_q <= wdata[NLED-1:0];
      st_q <= st_d;
    end
  end

  always_comb begin
    rd_d = '0;
    unique case (addr)
      AW'(OFS_DIRBUF): begin
        rd_d[NPINS-1:0]      = dir_q;
        rd_d[HI_OFS +: NPINS] = bufod_q;
      end
      AW'(OFS_DATA):   rd_d[NPINS-1:0] = rb;
      AW'(OFS_IRQCFG): begin
        rd_d[NPINS-1:0]      = ie_q;
        rd_d[HI_OFS +: NPINS] = pol_q;
      end
      AW'(OFS_STAT):   rd_d[NPINS-1:0] = st_q;
      AW'(OFS_LED):    rd_d[NLED-1:0]  = led_q;
      default:         rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      rdata_o <= rd_d;
      irq_o   <= |(st_q & ie_q);
    end
  end

  assign dir_o   = dir_q;
  assign bufod_o = bufod_q;
  assign dat_o   = dat_q;
  assign ie_o    = ie_q;
  assign st_o    = st_q;
  assign led_o   = led_q;
endmodule

// File: rtl/gpx_padmux.sv
module gpx_padmux
  import gpx_pkg::*;
#(
  parameter int NPINS = 12,
  parameter int NLED  = 8,
  parameter int TS_LO = 8,
  parameter int NTS   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] bufod,
  input  logic [NPINS-1:0] dat,
  input  logic [NLED-1:0]  led_mode,
  input  logic [NLED-1:0]  led_on,
  input  logic [NTS-1:0]   ts_oe,
  input  logic [NTS-1:0]   ts_val,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam bit IS_LED = (i < NLED);
    localparam bit IS_TS  = (i >= TS_LO) && (i < TS_LO + NTS);
    logic en_w, val_w, ovr_w, ovr_oe;

    if (IS_TS) begin : g_ts
      assign en_w  = dir[i] | ts_oe[i-TS_LO];
      assign val_w = ts_oe[i-TS_LO] ? ts_val[i-TS_LO] : dat[i];
    end else begin : g_plain
      assign en_w  = dir[i];
      assign val_w = dat[i];
    end

    if (IS_LED) begin : g_led
      assign ovr_w  = led_mode[i];
      assign ovr_oe = led_on[i];
    end else begin : g_noled
      assign ovr_w  = 1'b0;
      assign ovr_oe = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe[i]  <= 1'b0;
        pad_out[i] <= 1'b0;
      end else if (ovr_w) begin
        pad_oe[i]  <= ovr_oe;
        pad_out[i] <= 1'b0;
      end else if (gpx_buf_e'(bufod[i]) == BUF_OPENDRAIN) begin
        pad_oe[i]  <= en_w & ~val_w;
        pad_out[i] <= 1'b0;
      end else begin
        pad_oe[i]  <= en_w;
        pad_out[i] <= val_w;
      end
    end
  end
endmodule

// File: rtl/gpx_pin_ctrl.sv
module gpx_pin_ctrl
  import gpx_pkg::*;
#(
  parameter int NPINS  = 12,
  parameter int NLED   = 8,
  parameter int TS_LO  = 8,
  parameter int NTS    = 2,
  parameter int AW     = 3,
  parameter int DW     = 32,
  parameter int HI_OFS = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NLED-1:0]  strap_led,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NLED-1:0]  led_on,
  input  logic [NTS-1:0]   ts_oe,
  input  logic [NTS-1:0]   ts_val,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);
  logic [NPINS-1:0] sync_q, dir_q, bufod_q, dat_q, ie_q, st_q;
  logic [NLED-1:0]  led_q;

  gpx_sync #(.W(NPINS), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(sync_q)
  );

  gpx_regs #(
    .NPINS(NPINS), .NLED(NLED), .AW(AW), .DW(DW), .HI_OFS(HI_OFS)
  ) u_regs (
    .clk(clk), .rst(rst), .strap(strap_led), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .sync_in(sync_q), .dir_o(dir_q), .bufod_o(bufod_q),
    .dat_o(dat_q), .ie_o(ie_q), .st_o(st_q), .led_o(led_q),
    .rdata_o(reg_rdata), .irq_o(irq)
  );

  gpx_padmux #(
    .NPINS(NPINS), .NLED(NLED), .TS_LO(TS_LO), .NTS(NTS)
  ) u_pads (
    .clk(clk), .rst(rst), .dir(dir_q), .bufod(bufod_q), .dat(dat_q),
    .led_mode(led_q), .led_on(led_on), .ts_oe(ts_oe), .ts_val(ts_val),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );
endmodule

// File: rtl/gpx_pin_ctrl_chk.sv
module gpx_pin_ctrl_chk #(
  parameter int NPINS = 12,
  parameter int NLED  = 8,
  parameter int TS_LO = 8,
  parameter int NTS   = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_out,
  input logic             irq,
  input logic [NPINS-1:0] dir,
  input logic [NPINS-1:0] bufod,
  input logic [NPINS-1:0] ie,
  input logic [NPINS-1:0] status,
  input logic [NLED-1:0]  led
);
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && status == '0 && pad_oe == '0));

  a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(status & ie)));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    a_r3_od_never_high: assert property (@(posedge clk) disable iff (rst)
      (pad_oe[i] && $past(bufod[i])) |-> !pad_out[i]);

    if (i < NLED) begin : g_led
      a_r9_led_status_clear: assert property (@(posedge clk) disable iff (rst)
        led[i] |=> !status[i]);
      a_r9_led_drive_low: assert property (@(posedge clk) disable iff (rst)
        $past(led[i]) |-> !pad_out[i]);
    end else if (!((i >= TS_LO) && (i < TS_LO + NTS))) begin : g_plain
      a_r5_input_undriven: assert property (@(posedge clk) disable iff (rst)
        $past(!dir[i]) |-> !pad_oe[i]);
    end
  end
endmodule

bind gpx_pin_ctrl gpx_pin_ctrl_chk #(
  .NPINS(NPINS), .NLED(NLED), .TS_LO(TS_LO), .NTS(NTS)
) chk_i (
  .clk(clk), .rst(rst), .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq),
  .dir(dir_q), .bufod(bufod_q), .ie(ie_q), .status(st_q), .led(led_q)
);

// File: tb/gpx_pin_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpx_pin_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  strap_led = 8'h0F;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  led_on = '0;
  logic [1:0]  ts_oe = '0;
  logic [1:0]  ts_val = '0;
  logic [11:0] pad_in = '0;
  logic [11:0] pad_out, pad_oe;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit started = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpx_pin_ctrl dut_i (
    .clk(clk), .rst(rst), .strap_led(strap_led), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .led_on(led_on), .ts_oe(ts_oe), .ts_val(ts_val), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // behavioural reference model, one pin at a time
  bit [11:0] m_s1, m_s2, m_dir, m_buf, m_dat, m_ie, m_pol, m_st, m_oe, m_out;
  bit [7:0]  m_led;
  bit [31:0] m_rd;
  bit        m_irq;

  always @(posedge clk) begin
    bit [11:0] n_st, n_oe, n_out;
    bit [31:0] n_rd;
    bit        n_irq;
    started = 1;
    n_irq = 0;
    n_rd = 0;
    for (int i = 0; i < 12; i++) begin
      bit isled, en, val, outp;
      isled = (i < 8) && m_led[i];
      outp  = m_dir[i] && !isled;
      if (m_st[i] && m_ie[i]) n_irq = 1;
      // status
      if (isled) n_st[i] = 0;
      else if (m_ie[i] && (m_s2[i] == m_pol[i])) n_st[i] = 1;
      else if (reg_we && reg_addr == 3 && reg_wdata[i]) n_st[i] = 0;
      else n_st[i] = m_st[i];
      // pads
      en = m_dir[i];
      val = m_dat[i];
      if ((i == 8 || i == 9) && ts_oe[i-8]) begin
        en = 1;
        val = ts_val[i-8];
      end
      if (isled) begin
        n_oe[i] = led_on[i];
        n_out[i] = 0;
      end else if (m_buf[i]) begin
        n_oe[i] = en && !val;
        n_out[i] = 0;
      end else begin
        n_oe[i] = en;
        n_out[i] = val;
      end
      // read data
      case (reg_addr)
        0: begin n_rd[i] = m_dir[i]; n_rd[16+i] = m_buf[i]; end
        1: n_rd[i] = outp ? m_dat[i] : m_s2[i];
        2: begin n_rd[i] = m_ie[i]; n_rd[16+i] = m_pol[i]; end
        3: n_rd[i] = m_st[i];
        4: if (i < 8) n_rd[i] = m_led[i];
        default: ;
      endcase
    end
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_dir = 0; m_buf = 0; m_dat = 0; m_ie = 0;
      m_pol = 0; m_st = 0; m_oe = 0; m_out = 0; m_rd = 0; m_irq = 0;
      m_led = strap_led;
    end else begin
      m_st = n_st; m_oe = n_oe; m_out = n_out; m_rd = n_rd; m_irq = n_irq;
      if (reg_we) begin
        case (reg_addr)
          0: begin m_dir = reg_wdata[11:0]; m_buf = reg_wdata[27:16]; end
          1: m_dat = reg_wdata[11:0];
          2: begin m_ie = reg_wdata[11:0]; m_pol = reg_wdata[27:16]; end
          4: m_led = reg_wdata[7:0];
          default: ;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = pad_in;
    end
  end

  // cycle compare against the model
  always @(negedge clk) begin
    if (started && !done) begin
      n_cmp++;
      if (pad_oe !== m_oe || pad_out !== m_out) begin
        n_bad++;
        $display("FAIL R4 pads oe=%h out=%h expected oe=%h out=%h", pad_oe, pad_out, m_oe, m_out);
      end
      n_cmp++;
      if (irq !== m_irq) begin
        n_bad++;
        $display("FAIL R8 irq=%b expected %b", irq, m_irq);
      end
      n_cmp++;
      if (reg_rdata !== m_rd) begin
        n_bad++;
        $display("FAIL R2 rdata=%h expected %h", reg_rdata, m_rd);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    cyc(3);
    chk("R1 oe in reset", 32'(pad_oe), 0);
    rst = 0;
    cyc(1);
    chk("R1 irq after reset", 32'(irq), 0);
    rd(4, 32'h0F, "R1 led straps");
    rd(0, 0, "R1 dirbuf cleared");
    rd(2, 0, "R1 irqcfg cleared");

    // pin 11 open-drain, pin 10 push-pull
    wr(0, 32'h0800_0C00);
    wr(1, 32'h0000_0000);
    cyc(1);
    chk("R3 od low drive", 32'(pad_oe[11]), 1);
    chk("R3 od out zero", 32'(pad_out[11]), 0);
    chk("R4 pp drive", 32'({pad_oe[10], pad_out[10]}), 32'b10);
    wr(1, 32'h0000_0C00);
    chk("R11 oe not yet changed", 32'(pad_oe[11]), 1);
    cyc(1);
    chk("R3 od release", 32'(pad_oe[11]), 0);
    chk("R4 pp high", 32'({pad_oe[10], pad_out[10]}), 32'b11);
    rd(0, 32'h0800_0C00, "R2 dirbuf readback");

    // input readback latency
    @(negedge clk); reg_addr = 1;
    cyc(4);
    chk("R5 data read before", reg_rdata, 32'h0C00);
    pad_in = 12'h0A5;
    cyc(2);
    chk("R6 not yet visible", reg_rdata, 32'h0C00);
    cyc(1);
    chk("R6 visible third edge", reg_rdata, 32'h0CA5);
    chk("R5 input undriven", 32'(pad_oe[5]), 0);

    // interrupts on pin 5, high level
    wr(2, 32'h0020_0020);
    chk("R8 irq low at write", 32'(irq), 0);
    cyc(1);
    chk("R8 irq lags status", 32'(irq), 0);
    cyc(1);
    chk("R8 irq raised", 32'(irq), 1);
    rd(2, 32'h0020_0020, "R2 irqcfg readback");
    wr(3, 32'h20);
    cyc(2);
    rd(3, 32'h20, "R7 set wins over clear");
    pad_in = 12'h085;
    cyc(4);
    rd(3, 32'h20, "R7 sticky");
    wr(3, 32'h20);
    cyc(2);
    rd(3, 0, "R7 w1c clears");
    chk("R8 irq dropped", 32'(irq), 0);
    wr(2, 32'h0000_0020);
    cyc(2);
    rd(3, 32'h20, "R7 low polarity");
    wr(2, 0);
    wr(3, 32'h20);
    cyc(3);
    rd(3, 0, "R7 cleared after disable");
    chk("R8 irq idle", 32'(irq), 0);

    // LED pin 0 interrupt blocked
    wr(2, 32'h0001_0001);
    cyc(3);
    rd(3, 0, "R9 led status clear");
    chk("R9 led no irq", 32'(irq), 0);
    wr(2, 0);

    // LED drive
    led_on = 8'h05;
    cyc(2);
    chk("R9 led oe", 32'(pad_oe[3:0]), 32'h5);
    chk("R9 led out low", 32'(pad_out[3:0]), 0);
    wr(0, 32'h0800_0C01);
    wr(1, 32'h0000_0C01);
    cyc(1);
    chk("R9 dir/data ignored", 32'({pad_oe[0], pad_out[0]}), 32'b10);
    led_on = 8'h04;
    cyc(2);
    chk("R9 led release", 32'(pad_oe[0]), 0);
    wr(4, 32'h0E);
    cyc(1);
    chk("R9 leave led mode", 32'({pad_oe[0], pad_out[0]}), 32'b11);
    rd(4, 32'h0E, "R2 led readback");

    // timestamp pins
    ts_oe = 2'b01; ts_val = 2'b01;
    cyc(2);
    chk("R10 ts drives pp", 32'({pad_oe[8], pad_out[8]}), 32'b11);
    wr(0, 32'h0900_0C01);
    ts_val = 2'b00;
    cyc(2);
    chk("R10 ts od low", 32'({pad_oe[8], pad_out[8]}), 32'b10);
    ts_val = 2'b01;
    cyc(2);
    chk("R10 ts od release", 32'(pad_oe[8]), 0);
    ts_oe = 2'b00;
    ts_val = 2'b00;
    cyc(2);
    chk("R10 no enable", 32'(pad_oe[8]), 0);
    wr(0, 32'h0900_0D01);
    cyc(1);
    chk("R10 dir enable", 32'({pad_oe[8], pad_out[8]}), 32'b10);
    rd(5, 0, "R2 unused address");

    cyc(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule